// File: doc/BRIEF.md
# Ping-Pong Block-Reversing Sample Buffer

This block takes a stream of samples and puts them out again in fixed-length blocks, with the order inside each block reversed. It holds two small last-in-first-out banks. One bank takes the incoming samples. The other plays back the previous block, newest sample first. A swap strobe, normally raised once per block on the cycle that carries the block's last sample, exchanges the roles of the two banks.

The reversed stream feeds the backward-running half of a folded symmetric filter delay line, so that mirrored samples meet at the pre-adders. A reversal enable picks between this reversed output and a straight delayed copy of the input. Both paths take the same number of cycles, so the enable can be switched without retiming the rest of the datapath.

The block length `DEPTH` (default 3) and the sample width `DATA_W` (default 10) are parameters. A short block, caused by an early swap, is padded with zeros. Extra samples that arrive after a bank is full are dropped.

Top module: `blk_rev_pingpong`

## Requirements
- R1: After reset `dout` is 0. While `rev_en` is 1 and no swap has happened since reset, `dout` stays 0 whatever `din` carries.
- R2: With `rev_en` = 1, take DEPTH samples a0..a(DEPTH-1) on consecutive rising edges, with `swap` = 1 (active high) only on the edge of the last one. On the DEPTH edges that follow, `dout` shows a(DEPTH-1), then a(DEPTH-2), down to a0. The first of these appears after the first edge following the swap edge.
- R3: With `swap` raised on every DEPTH-th edge, consecutive blocks come out back to back with no gap, each one reversed. A block is written into one bank while the other bank plays back.
- R4: If `swap` comes after only k < DEPTH samples have been written (the swap edge's own sample counts), playback starts with DEPTH-k zeros, followed by the k samples newest first.
- R5: Samples that arrive after a bank already holds DEPTH samples, with no swap between, are discarded. This includes a sample on the swap edge. The block plays back only its first DEPTH samples.
- R6: With `rev_en` = 1, once a block has been played back in full and no new swap has come, `dout` is 0.
- R7: With `rev_en` = 0, the sample taken on edge k appears on `dout` after edge k+DEPTH. This is DEPTH delay stages plus the output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| din | input | DATA_W | Incoming sample, one per clock |
| swap | input | 1 | Exchanges write and read banks; this edge's sample belongs to the closing block |
| rev_en | input | 1 | 1 selects the block-reversed stream, 0 the straight delayed stream |
| dout | output | DATA_W | Registered output sample |

## Verification
The assertions watch every cycle for three things: a full block's newest sample reaching `dout` two edges after the swap, the zero that leads an early-swapped block, and `dout` holding 0 once playback is used up. They also check that the straight path follows its delay line, and that the bank select moves only on a swap. The exact order of a whole reversed block, back-to-back blocks, dropped overflow samples and the reset behaviour are shown only by the bench's scenarios, which follow complete sample sequences against values computed from the requirements.

// File: rtl/blk_rev_pkg.sv
package blk_rev_pkg;
   localparam int DEF_DATA_W = 10;
   localparam int DEF_DEPTH  = 3;

   // Width of a counter that must reach the value n inclusive
   function automatic int cnt_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/blk_rev_bank.sv
module blk_rev_bank #(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 3,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] slot_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (wr_en && (int'(wr_idx) == i)) slot_q[i] <= wr_data;
            else if (clr)                     slot_q[i] <= '0;
         end
      end
   end

   assign rd_data = slot_q[rd_idx];
endmodule

// File: rtl/blk_rev_delay.sv
module blk_rev_delay #(
   parameter int DATA_W = 10,
   parameter int STAGES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] d_out
);
   logic [DATA_W-1:0] stage_q [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stage_q[g] <= '0;
            else if (g == 0) stage_q[g] <= d_in;
            else             stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
         end
      end
   endgenerate

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/blk_rev_ctrl.sv
module blk_rev_ctrl #(
   parameter int DEPTH = 3,
   localparam int CNT_W = blk_rev_pkg::cnt_width(DEPTH),
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             swap,
   output logic             wr_sel,
   output logic [CNT_W-1:0] wcnt,
   output logic [CNT_W-1:0] rcnt,
   output logic             wr_room,
   output logic             rd_live,
   output logic [IDX_W-1:0] wr_idx,
   output logic [IDX_W-1:0] rd_idx
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(DEPTH - 1);

   assign wr_room = (wcnt < FULL);
   assign rd_live = (rcnt < FULL);
   assign wr_idx  = IDX_W'(wcnt);
   assign rd_idx  = IDX_W'(TOP - rcnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_sel <= 1'b0;
         wcnt   <= '0;
         rcnt   <= FULL;   // read side starts exhausted (zeros)
      end else if (swap) begin
         wr_sel <= ~wr_sel;
         wcnt   <= '0;
         rcnt   <= '0;
      end else begin
         if (wr_room) wcnt <= wcnt + 1'b1;
         if (rd_live) rcnt <= rcnt + 1'b1;
      end
   end
endmodule

// File: rtl/blk_rev_pingpong.sv
module blk_rev_pingpong #(
   parameter int DATA_W = blk_rev_pkg::DEF_DATA_W,
   parameter int DEPTH  = blk_rev_pkg::DEF_DEPTH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   input  logic              swap,
   input  logic              rev_en,
   output logic [DATA_W-1:0] dout
);
   localparam int CNT_W = blk_rev_pkg::cnt_width(DEPTH);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("blk_rev_pingpong: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("blk_rev_pingpong: DEPTH must be at least 2");
      end
   endgenerate

   logic             wr_sel;
   logic [CNT_W-1:0] wcnt;
   logic [CNT_W-1:0] rcnt;
   logic             wr_room;
   logic             rd_live;
   logic [IDX_W-1:0] wr_idx;
   logic [IDX_W-1:0] rd_idx;
   logic [DATA_W-1:0] bank_rd [2];
   logic [DATA_W-1:0] dly_out;
   logic [DATA_W-1:0] rev_sample;
   logic [DATA_W-1:0] dout_q;

   blk_rev_ctrl #(.DEPTH(DEPTH)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .swap    (swap),
      .wr_sel  (wr_sel),
      .wcnt    (wcnt),
      .rcnt    (rcnt),
      .wr_room (wr_room),
      .rd_live (rd_live),
      .wr_idx  (wr_idx),
      .rd_idx  (rd_idx)
   );

   generate
      for (genvar b = 0; b < 2; b++) begin : g_bank
         logic is_wr;
         assign is_wr = (wr_sel == 1'(b));
         blk_rev_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) bank_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (swap && !is_wr),   // bank becoming the write side starts empty
            .wr_en   (is_wr && wr_room),
            .wr_idx  (wr_idx),
            .wr_data (din),
            .rd_idx  (rd_idx),
            .rd_data (bank_rd[b])
         );
      end
   endgenerate

   blk_rev_delay #(.DATA_W(DATA_W), .STAGES(DEPTH)) dly_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (din),
      .d_out (dly_out)
   );

   assign rev_sample = rd_live ? bank_rd[~wr_sel] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else        dout_q <= rev_en ? rev_sample : dly_out;
   end

   assign dout = dout_q;
endmodule

// File: rtl/blk_rev_checker.sv
module blk_rev_checker #(
   parameter int DATA_W = 10,
   parameter int DEPTH  = 3,
   localparam int CNT_W = blk_rev_pkg::cnt_width(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] din,
   input logic              swap,
   input logic              rev_en,
   input logic [DATA_W-1:0] dout,
   input logic [CNT_W-1:0]  wcnt,
   input logic [CNT_W-1:0]  rcnt,
   input logic              wr_sel,
   input logic [DATA_W-1:0] dly_out
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(DEPTH - 1);

   AST_NEWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && wcnt == TOP && rev_en) ##1 rev_en |=> dout == $past(din, 2)); // R2

   AST_SHORT_BLOCK_PAD: assert property (@(posedge clk) disable iff (!rst_n)
      (swap && wcnt < TOP && rev_en) ##1 rev_en |=> dout == '0); // R4

   AST_DRAINED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rev_en && !swap && rcnt == FULL) |=> dout == '0); // R6

   AST_STRAIGHT_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      !rev_en |=> dout == $past(dly_out)); // R7

   AST_BANK_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      swap |=> wr_sel != $past(wr_sel)); // R3

   AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !swap |=> $stable(wr_sel)); // R3
endmodule

bind blk_rev_pingpong blk_rev_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .din     (din),
   .swap    (swap),
   .rev_en  (rev_en),
   .dout    (dout),
   .wcnt    (wcnt),
   .rcnt    (rcnt),
   .wr_sel  (wr_sel),
   .dly_out (dly_out)
);

// File: tb/blk_rev_pingpong_tb_top.sv
module blk_rev_pingpong_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W = 10;
   localparam int DEPTH  = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] din = '0;
   logic              swap = 1'b0;
   logic              rev_en = 1'b1;
   logic [DATA_W-1:0] dout;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   blk_rev_pingpong #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (din),
      .swap   (swap),
      .rev_en (rev_en),
      .dout   (dout)
   );

   task automatic check(input string tag, input logic [DATA_W-1:0] exp);
      n_checks++;
      if (dout !== exp) begin
         n_fails++;
         $display("FAIL %s: dout actual %0d expected %0d", tag, dout, exp);
      end
   endtask

   // Drive one sample, wait for the edge, settle past it
   task automatic tick(input int d, input logic s);
      din  = DATA_W'(d);
      swap = s;
      @(posedge clk);
      #1;
   endtask

   task automatic sync_swap();
      tick(0, 1'b1);
   endtask

   task automatic t_reset();
      rst_n  = 1'b0;
      rev_en = 1'b1;
      #(CLK_PERIOD*2);
      check("R1 in reset", '0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 5; i++) begin
         tick(300 + i, 1'b0);
         check("R1 no swap yet", '0);
      end
   endtask

   task automatic t_full_block();
      sync_swap();
      tick(11, 1'b0);
      tick(22, 1'b0);
      tick(33, 1'b1);
      tick(0, 1'b0); check("R2 slot newest", 10'd33);
      tick(0, 1'b0); check("R2 slot middle", 10'd22);
      tick(0, 1'b0); check("R2 slot oldest", 10'd11);
      tick(0, 1'b0); check("R6 drained", '0);
      tick(0, 1'b0); check("R6 drained again", '0);
   endtask

   task automatic t_stream();
      sync_swap();
      for (int n = 0; n < 15; n++) begin
         tick(100 + n, (n % 3) == 2);
         if (n >= 3) begin
            int b = n / 3 - 1;
            int p = n % 3;
            check("R3 back-to-back", DATA_W'(100 + 3*b + (2 - p)));
         end
      end
   endtask

   task automatic t_early();
      sync_swap();
      tick(55, 1'b0);
      tick(66, 1'b1);
      tick(0, 1'b0); check("R4 pad zero", '0);
      tick(0, 1'b0); check("R4 newest", 10'd66);
      tick(0, 1'b0); check("R4 oldest", 10'd55);
   endtask

   task automatic t_drop();
      sync_swap();
      tick(1, 1'b0);
      tick(2, 1'b0);
      tick(3, 1'b0);
      tick(4, 1'b0);
      tick(5, 1'b1);
      tick(0, 1'b0); check("R5 kept newest", 10'd3);
      tick(0, 1'b0); check("R5 kept middle", 10'd2);
      tick(0, 1'b0); check("R5 kept oldest", 10'd1);
   endtask

   task automatic t_pass();
      rev_en = 1'b0;
      for (int n = 0; n < 12; n++) begin
         tick(200 + n, (n % 3) == 2);
         if (n >= DEPTH) check("R7 straight delay", DATA_W'(200 + n - DEPTH));
      end
      rev_en = 1'b1;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run actual hung expected finished");
         summary();
      end
   end

   initial begin
      t_reset();
      t_full_block();
      t_stream();
      t_early();
      t_drop();
      t_pass();
      t_full_block();
      done = 1'b1;
      summary();
   end
endmodule